// File: doc/BRIEF.md
# Chip-Enable Nibble Memory Slave

This block is a single-clock storage slave holding 4-bit words behind an 18-bit address. A host selects it with an active-low chip enable and picks the direction with a read/write select. A write is committed on the clock edge that samples it. A read returns its nibble on a dedicated output bus a fixed number of cycles later, flagged by a one-cycle valid strobe for each returned word. The host may start accesses only while the slave's availability flag is high.

The number of storage locations is a parameter and need not be a power of two. The default here is 1920 words. A full-size instance sets it to 245760, and only addresses below that count are then backed by storage. An access at or beyond the limit is never aliased onto a lower location. A write there is dropped, a read there still produces a valid beat carrying a fixed fill value, and in both cases a one-cycle error flag is raised. Memory contents survive reset. Only the control state is cleared.

Top module: `nibble_mem_slave`

## Requirements
- R1: With `ready_o` high, a clock edge that samples `cs_n_i`=0 and `rd_nwr_i`=0 (0 means write) at an address below DEPTH stores `wdata_i` at that address in that cycle, and a later read of the address returns it.
- R2: While `cs_n_i` is 1 no access occurs, whatever the other inputs are: nothing is stored, no beat is returned and `range_err_o` stays low.
- R3: A read (`rd_nwr_i`=1) sampled at edge k with an in-range address drives `rvalid_o` high for exactly one cycle, between edges k+1 and k+2 (RD_STAGES=2), with the stored nibble on `rdata_o`, and `wdata_i` has no effect on a read.
- R4: Reads sampled on consecutive edges return beats on consecutive cycles, in request order.
- R5: A write whose address is at or above DEPTH is discarded. It does not alter the location selected by the low address bits. `range_err_o` is high for the one cycle after the sampling edge.
- R6: A read whose address is at or above DEPTH still returns one valid beat at the normal latency, carrying 4'hF, and `range_err_o` is high for the one cycle after the sampling edge.
- R7: While `rst_n` is low (synchronous, active low), `ready_o`, `rvalid_o` and `range_err_o` are low and a read in flight is dropped. `ready_o` rises at the first edge that samples `rst_n` high and then stays high. Memory contents are not cleared.
- R8: An access sampled on an edge where `ready_o` is low (the edge releasing reset) is ignored.
- R9: Address DEPTH-1 is a valid location and address DEPTH is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n_i | input | 1 | Chip enable, active low |
| rd_nwr_i | input | 1 | Direction select: 0 write, 1 read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 4 | Write data, ignored on reads |
| ready_o | output | 1 | Availability flag; host starts accesses only while high |
| rdata_o | output | 4 | Read data, qualified by rvalid_o |
| rvalid_o | output | 1 | One-cycle strobe per returned nibble |
| range_err_o | output | 1 | One-cycle pulse after an out-of-range access |

## Verification
Writes followed by isolated reads show that data is stored and that the beat arrives at the stated latency, not one cycle early or late. A run of reads on consecutive edges with shuffled addresses, one of them out of range, tells in-order pipelining apart from dropped or reordered beats. It also shows that an out-of-range read keeps its slot. Writes to addresses past the limit whose low bits match a written location, the DEPTH-1/DEPTH pair and the top address separate a true limit compare from power-of-two wrapping. Idle cycles with active-looking inputs, a read cut off by reset and an access on the reset-release edge show that nothing leaks through.

// File: rtl/nms_pkg.sv
package nms_pkg;

   localparam int unsigned NMS_ADDR_W = 18;
   localparam int unsigned NMS_DATA_W = 4;
   localparam int unsigned NMS_DEPTH  = 1920;

   typedef enum logic {
      NMS_OP_WRITE = 1'b0,
      NMS_OP_READ  = 1'b1
   } nms_op_e;

   typedef struct packed {
      logic accept;   // enabled access while available
      logic is_rd;    // direction of the accepted access
      logic oor;      // address at or beyond the limit
      logic wr_en;    // in-range write to commit
      logic rd_issue; // read entering the return pipeline
   } nms_cmd_t;

endpackage

// File: rtl/nms_ready.sv
module nms_ready (
   input  logic clk,
   input  logic rst_n,
   output logic ready_o
);

   logic ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign ready_o = ready_q;

   AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> ready_q); // R7

endmodule

// File: rtl/nms_decode.sv
module nms_decode
   import nms_pkg::*;
#(
   parameter int unsigned ADDR_W = NMS_ADDR_W,
   parameter int unsigned DEPTH  = NMS_DEPTH,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              cs_n_i,
   input  logic              rd_nwr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ready_i,
   output nms_cmd_t          cmd_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth_small
         $error("nms_decode: DEPTH must be at least 2");
      end
      if (DEPTH > (64'd1 << ADDR_W)) begin : g_bad_depth_large
         $error("nms_decode: DEPTH exceeds the address space");
      end
      if (IDX_W > ADDR_W) begin : g_bad_idx
         $error("nms_decode: index wider than address");
      end
   endgenerate

   nms_op_e op;
   logic    in_range;

   always_comb begin
      op             = nms_op_e'(rd_nwr_i);
      in_range       = ({1'b0, addr_i} < LIMIT);
      cmd_o.accept   = ready_i && !cs_n_i;
      cmd_o.is_rd    = (op == NMS_OP_READ);
      cmd_o.oor      = !in_range;
      cmd_o.wr_en    = cmd_o.accept && !cmd_o.is_rd && in_range;
      cmd_o.rd_issue = cmd_o.accept && cmd_o.is_rd;
      idx_o          = addr_i[IDX_W-1:0];
   end

endmodule

// File: rtl/nms_store.sv
module nms_store #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned DEPTH  = 1920,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] q;

   // single port: one of write or read per edge
   always_ff @(posedge clk) begin
      if (we_i) mem[idx_i] <= wdata_i;
      if (re_i) q <= mem[idx_i];
   end

   assign rdata_o = q;

   AST_SINGLE_PORT: assert property (@(posedge clk)
      !(we_i && re_i)); // R1

endmodule

// File: rtl/nms_rd_pipe.sv
module nms_rd_pipe #(
   parameter int unsigned        DATA_W = 4,
   parameter int unsigned        STAGES = 2,
   parameter logic [DATA_W-1:0] FILL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              oor_i,
   input  logic [DATA_W-1:0] mem_q_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("nms_rd_pipe: STAGES must be at least 1");
      end
   endgenerate

   logic              v0_q;
   logic              oor0_q;
   logic [DATA_W-1:0] dtap [STAGES];
   logic              vtap [STAGES];

   // stage 0 is aligned with the storage read register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v0_q   <= 1'b0;
         oor0_q <= 1'b0;
      end else begin
         v0_q   <= issue_i;
         oor0_q <= issue_i && oor_i;
      end
   end

   assign vtap[0] = v0_q;
   assign dtap[0] = oor0_q ? FILL : mem_q_i;

   AST_ISSUE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> v0_q); // R3

   genvar gi;
   generate
      for (gi = 1; gi < STAGES; gi++) begin : g_stage
         logic              v_q;
         logic [DATA_W-1:0] d_q;

         always_ff @(posedge clk) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= vtap[gi-1];
         end

         always_ff @(posedge clk) begin
            d_q <= dtap[gi-1];
         end

         assign vtap[gi] = v_q;
         assign dtap[gi] = d_q;

         AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
            vtap[gi-1] |=> vtap[gi]); // R4
         AST_NO_GHOST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
            !vtap[gi-1] |=> !vtap[gi]); // R3
      end
   endgenerate

   assign rvalid_o = vtap[STAGES-1];
   assign rdata_o  = dtap[STAGES-1];

endmodule

// File: rtl/nibble_mem_slave.sv
module nibble_mem_slave
   import nms_pkg::*;
#(
   parameter int unsigned        ADDR_W    = NMS_ADDR_W,
   parameter int unsigned        DATA_W    = NMS_DATA_W,
   parameter int unsigned        DEPTH     = NMS_DEPTH,
   parameter int unsigned        RD_STAGES = 2,
   parameter logic [DATA_W-1:0] OOR_FILL  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              rd_nwr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic              range_err_o
);

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("nibble_mem_slave: DATA_W must be at least 1");
      end
   endgenerate

   nms_cmd_t          cmd;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] mem_q;
   logic              err_q;

   nms_ready u_ready (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_o (ready_o)
   );

   nms_decode #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) u_decode (
      .cs_n_i   (cs_n_i),
      .rd_nwr_i (rd_nwr_i),
      .addr_i   (addr_i),
      .ready_i  (ready_o),
      .cmd_o    (cmd),
      .idx_o    (idx)
   );

   nms_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk     (clk),
      .we_i    (cmd.wr_en),
      .re_i    (cmd.rd_issue && !cmd.oor),
      .idx_i   (idx),
      .wdata_i (wdata_i),
      .rdata_o (mem_q)
   );

   nms_rd_pipe #(
      .DATA_W (DATA_W),
      .STAGES (RD_STAGES),
      .FILL   (OOR_FILL)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_i  (cmd.rd_issue),
      .oor_i    (cmd.oor),
      .mem_q_i  (mem_q),
      .rdata_o  (rdata_o),
      .rvalid_o (rvalid_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= cmd.accept && cmd.oor;
   end

   assign range_err_o = err_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_i |=> !range_err_o); // R2
   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      range_err_o |-> $past(!cs_n_i && (addr_i >= ADDR_W'(DEPTH)))); // R5
   AST_NO_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.wr_en |-> (addr_i < ADDR_W'(DEPTH))); // R5
   AST_NOT_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |=> !range_err_o); // R8

endmodule

// File: tb/nibble_mem_slave_test.sv
module nibble_mem_slave_test;

   localparam int unsigned DEPTH = 1920;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n_i = 1'b1;
   logic       rd_nwr_i = 1'b0;
   logic [17:0] addr_i = '0;
   logic [3:0] wdata_i = 4'hF;
   logic       ready_o;
   logic [3:0] rdata_o;
   logic       rvalid_o;
   logic       range_err_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nibble_mem_slave #(.DEPTH(DEPTH)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n_i),
      .rd_nwr_i    (rd_nwr_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .ready_o     (ready_o),
      .rdata_o     (rdata_o),
      .rvalid_o    (rvalid_o),
      .range_err_o (range_err_o)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic cs_n, input logic rd, input logic [17:0] a, input logic [3:0] d);
      cs_n_i = cs_n; rd_nwr_i = rd; addr_i = a; wdata_i = d;
   endtask

   task automatic go_idle();
      drive(1'b1, 1'b0, 18'd0, 4'hF);
   endtask

   task automatic t_write(input string tag, input logic [17:0] a, input logic [3:0] d, input logic exp_err);
      @(negedge clk); drive(1'b0, 1'b0, a, d);
      @(negedge clk); go_idle();
      chk(tag, "write err flag", {31'd0, range_err_o}, {31'd0, exp_err});
      chk(tag, "no beat on write", {31'd0, rvalid_o}, 32'd0);
   endtask

   task automatic t_read(input string tag, input logic [17:0] a, input logic [3:0] exp_d, input logic exp_err);
      @(negedge clk); drive(1'b0, 1'b1, a, 4'h6);
      @(negedge clk); go_idle();
      chk(tag, "read err flag", {31'd0, range_err_o}, {31'd0, exp_err});
      chk(tag, "beat not early", {31'd0, rvalid_o}, 32'd0);
      @(negedge clk);
      chk(tag, "beat valid", {31'd0, rvalid_o}, 32'd1);
      chk(tag, "beat data", {28'd0, rdata_o}, {28'd0, exp_d});
      chk(tag, "err one cycle", {31'd0, range_err_o}, 32'd0);
      @(negedge clk);
      chk(tag, "beat one cycle", {31'd0, rvalid_o}, 32'd0);
   endtask

   task automatic test_reset_state();
      go_idle();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7", "ready in reset", {31'd0, ready_o}, 32'd0);
      chk("R7", "valid in reset", {31'd0, rvalid_o}, 32'd0);
      chk("R7", "err in reset", {31'd0, range_err_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7", "ready after release", {31'd0, ready_o}, 32'd1);
   endtask

   task automatic test_write_read();
      t_write("R1", 18'd0, 4'hA, 1'b0);
      t_write("R1", 18'd1, 4'h5, 1'b0);
      t_write("R9", 18'(DEPTH-1), 4'hC, 1'b0);
      t_write("R1", 18'd7, 4'h3, 1'b0);
      t_write("R1", 18'd10, 4'h2, 1'b0);
      t_read("R3", 18'd0, 4'hA, 1'b0);
      t_read("R3", 18'd1, 4'h5, 1'b0);
      t_read("R9", 18'(DEPTH-1), 4'hC, 1'b0);
   endtask

   task automatic test_idle_ignored();
      @(negedge clk); drive(1'b1, 1'b0, 18'd0, 4'h3);
      @(negedge clk);
      chk("R2", "idle write err", {31'd0, range_err_o}, 32'd0);
      drive(1'b1, 1'b1, 18'(DEPTH), 4'h3);
      @(negedge clk);
      chk("R2", "idle oor err", {31'd0, range_err_o}, 32'd0);
      go_idle();
      @(negedge clk);
      chk("R2", "idle no beat", {31'd0, rvalid_o}, 32'd0);
      @(negedge clk);
      chk("R2", "idle no beat late", {31'd0, rvalid_o}, 32'd0);
      t_read("R2", 18'd0, 4'hA, 1'b0);
   endtask

   task automatic test_back_to_back();
      logic [17:0] ra [5];
      logic [3:0]  rd [5];
      logic        re [5];
      t_write("R4", 18'd20, 4'h1, 1'b0);
      t_write("R4", 18'd21, 4'h2, 1'b0);
      t_write("R4", 18'd22, 4'h3, 1'b0);
      t_write("R4", 18'd23, 4'h4, 1'b0);
      ra[0] = 18'd23; rd[0] = 4'h4; re[0] = 1'b0;
      ra[1] = 18'd21; rd[1] = 4'h2; re[1] = 1'b0;
      ra[2] = 18'd22; rd[2] = 4'h3; re[2] = 1'b0;
      ra[3] = 18'(DEPTH); rd[3] = 4'hF; re[3] = 1'b1;
      ra[4] = 18'd20; rd[4] = 4'h1; re[4] = 1'b0;
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         if (j >= 1 && j <= 5)
            chk("R4", "burst err", {31'd0, range_err_o}, {31'd0, re[j-1]});
         if (j >= 2 && j <= 6) begin
            chk("R4", "burst valid", {31'd0, rvalid_o}, 32'd1);
            chk("R4", "burst order", {28'd0, rdata_o}, {28'd0, rd[j-2]});
         end else begin
            chk("R4", "burst gap", {31'd0, rvalid_o}, 32'd0);
         end
         if (j < 5) drive(1'b0, 1'b1, ra[j], 4'h0);
         else       go_idle();
      end
   endtask

   task automatic test_oor_write();
      t_write("R5", 18'(DEPTH), 4'h7, 1'b1);
      t_write("R5", 18'd2058, 4'hE, 1'b1);
      t_write("R5", 18'h3FFFF, 4'h1, 1'b1);
      t_write("R5", 18'(2048 + DEPTH - 1), 4'h9, 1'b1);
      t_read("R5", 18'd10, 4'h2, 1'b0);
      t_read("R5", 18'(DEPTH-1), 4'hC, 1'b0);
   endtask

   task automatic test_oor_read();
      t_read("R6", 18'(DEPTH), 4'hF, 1'b1);
      t_read("R6", 18'd2058, 4'hF, 1'b1);
      t_read("R6", 18'h3FFFF, 4'hF, 1'b1);
   endtask

   task automatic test_reset_effects();
      // read cut off by reset
      @(negedge clk); drive(1'b0, 1'b1, 18'd0, 4'h0);
      @(negedge clk); go_idle(); rst_n = 1'b0;
      @(negedge clk);
      chk("R7", "in-flight beat dropped", {31'd0, rvalid_o}, 32'd0);
      chk("R7", "ready low in reset", {31'd0, ready_o}, 32'd0);
      @(negedge clk);
      chk("R7", "no late beat", {31'd0, rvalid_o}, 32'd0);
      // access on the release edge, while ready is low
      drive(1'b0, 1'b0, 18'd7, 4'hC);
      rst_n = 1'b1;
      @(negedge clk); go_idle();
      chk("R8", "ready after release", {31'd0, ready_o}, 32'd1);
      chk("R8", "ignored access err", {31'd0, range_err_o}, 32'd0);
      t_read("R8", 18'd7, 4'h3, 1'b0);
      t_read("R7", 18'd1, 4'h5, 1'b0);
   endtask

   initial begin
      test_reset_state();
      test_write_read();
      test_idle_ignored();
      test_back_to_back();
      test_oor_write();
      test_oor_read();
      test_reset_effects();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule